// File: doc/BRIEF.md
# Token-Passing Shared Broadcast Channel

This block shares one broadcast medium among a set of hubs by circulating a single token around them. Only the hub that holds the token may put flits on the channel. It keeps the token from the head flit of a packet until that packet's tail flit has been sent, so packets are never interleaved on the medium. A holder with nothing to send gives the token up after one cycle. Token order is a fixed ring by hub index.

The channel is modelled as a one-cycle registered bus that every hub observes. Each flit carries a destination index. Only the hub whose index matches that field stores the flit, in a small receive queue. All other hubs see the flit and discard it. A sender is held off while the destination's queue has no free slot, counting a flit already on the bus toward it. The flit then waits at the sender until the consumer frees room.

Top module: `wtok_channel`

## Requirements
- R1: After reset the token is at hub 0 (`token_out` = 0001 for four hubs), `bus_valid` is 0 and every receive queue is empty.
- R2: `tx_ready[k]` is asserted only for the hub holding the token. A requesting hub without the token gets no grant.
- R3: A flit granted at a clock edge is on the bus after that edge, with its data, its destination index, its tail bit and `bus_valid` = 1.
- R4: A bus flit is stored only by the hub whose index equals its destination field, one edge after it is on the bus. Every other hub's queue is unchanged.
- R5: Once a head flit (`tx_head` = 1, `tx_tail` = 0) is granted, the token stays with that hub through gaps in `tx_valid` until its tail flit is granted.
- R6: The token advances to hub (holder + 1) mod NUM_HUBS at the edge where the tail flit is granted. A flit with both head and tail set is a one-flit packet.
- R7: A holder that is not mid-packet and has `tx_valid` low passes the token to the next hub at the next edge.
- R8: The holder is not granted while the destination queue's occupancy plus any flit on the bus for that queue equals RX_DEPTH (8). The flit stays offered and is granted in the cycle after a pop frees a slot.
- R9: Exactly one bit of `token_out` is set at all times out of reset.
- R10: Each receive queue presents flits in arrival order. `rx_data`/`rx_tail` show the oldest flit while `rx_valid` is 1, and `rx_pop` removes it at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | NUM_HUBS | Hub k offers a flit |
| tx_head | input | NUM_HUBS | Offered flit is a packet head |
| tx_tail | input | NUM_HUBS | Offered flit is a packet tail |
| tx_dest | input | NUM_HUBS*IDX_W | Destination hub index, field k at bits k*IDX_W |
| tx_data | input | NUM_HUBS*DATA_W | Flit payload, field k at bits k*DATA_W |
| tx_ready | output | NUM_HUBS | Offered flit of hub k is taken at this edge |
| token_out | output | NUM_HUBS | One-hot token holder |
| bus_valid | output | 1 | Broadcast bus carries a flit |
| bus_dest | output | IDX_W | Destination index of the bus flit |
| bus_data | output | DATA_W | Payload of the bus flit |
| bus_tail | output | 1 | Bus flit is a tail |
| rx_valid | output | NUM_HUBS | Receive queue k is not empty |
| rx_data | output | NUM_HUBS*DATA_W | Oldest flit payload of queue k |
| rx_tail | output | NUM_HUBS | Oldest flit of queue k is a tail |
| rx_pop | input | NUM_HUBS | Remove the oldest flit of queue k |

## Verification
A grant shows on `tx_ready` in the same cycle the flit is offered. The flit is on the bus one edge later and in the matching receive queue two edges later. The token moves at the edge that takes a tail, or one edge after an idle hold. The bench drives inputs on the falling edge and samples shortly after it, so each result is read in the half-cycle after the rising edge at which it is due. For back-pressure, the bench counts the grants into a full queue and checks that the blocked flit is granted in the first cycle after the pop edge.

// File: rtl/wtok_pkg.sv
package wtok_pkg;

  // Next position on the fixed token ring.
  function automatic int ring_after(int idx, int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // A queue can take one more flit when stored plus in-flight stays below depth.
  function automatic bit slot_free(int stored, bit in_flight, int depth);
    return (stored + int'(in_flight)) < depth;
  endfunction

endpackage

// File: rtl/wtok_token_ring.sv
module wtok_token_ring #(
  parameter int NUM_HUBS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                req_head,
  input  logic                req_tail,
  input  logic                dest_ok,
  output logic [IDX_W-1:0]    hold_idx,
  output logic [NUM_HUBS-1:0] hold_oh,
  output logic                grant,
  output logic                pass_evt
);
  logic in_pkt;

  assign grant    = req && dest_ok;
  assign pass_evt = (grant && req_tail) || (!req && !in_pkt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_idx <= '0;
      in_pkt   <= 1'b0;
    end else begin
      if (grant) in_pkt <= !req_tail;
      if (pass_evt) hold_idx <= IDX_W'(wtok_pkg::ring_after(int'(hold_idx), NUM_HUBS));
    end
  end

  for (genvar k = 0; k < NUM_HUBS; k++) begin : g_oh
    assign hold_oh[k] = (int'(hold_idx) == k);
  end

  // R9: a single token at all times
  a_r9_one_token: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hold_oh) == 1);
  // R6 / R7: a pass moves the token one ring step
  a_r6_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
    pass_evt |=> hold_idx == IDX_W'(wtok_pkg::ring_after(int'($past(hold_idx)), NUM_HUBS)));
  // R5: mid-packet holder without tail grant keeps the token
  a_r5_keep_mid_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && !(grant && req_tail)) |=> $stable(hold_idx));
  // R5: a packet opens with a head flit
  a_r5_head_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !in_pkt) |-> req_head);
endmodule

// File: rtl/wtok_rx_queue.sv
module wtok_rx_queue #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 2,
  parameter int HUB_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_v,
  input  logic [IDX_W-1:0]  bus_dest,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_tail,
  input  logic              pop,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              q_tail,
  output logic              has_room
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] MY_ADDR = IDX_W'(HUB_ID);

  logic [DATA_W:0]  store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             take, deq;

  assign take     = bus_v && (bus_dest == MY_ADDR);
  assign deq      = pop && q_valid;
  assign q_valid  = (count != '0);
  assign q_data   = store[rd_ptr][DATA_W-1:0];
  assign q_tail   = store[rd_ptr][DATA_W];
  assign has_room = wtok_pkg::slot_free(int'(count), take, DEPTH);

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (take) begin
        store[wr_ptr] <= {bus_tail, bus_data};
        wr_ptr        <= bump(wr_ptr);
      end
      if (deq) rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(take) - CNT_W'(deq);
    end
  end

  // R8: the sender check keeps the queue from overflowing
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> int'(count) < DEPTH);
  // R4: a flit for another hub leaves this queue untouched
  a_r4_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_v && bus_dest != MY_ADDR && !deq) |=> $stable(count));
endmodule

// File: rtl/wtok_channel.sv
module wtok_channel #(
  parameter int NUM_HUBS = 4,
  parameter int DATA_W   = 16,
  parameter int RX_DEPTH = 8,
  parameter int IDX_W    = (NUM_HUBS > 1) ? $clog2(NUM_HUBS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_HUBS-1:0]          tx_valid,
  input  logic [NUM_HUBS-1:0]          tx_head,
  input  logic [NUM_HUBS-1:0]          tx_tail,
  input  logic [NUM_HUBS*IDX_W-1:0]    tx_dest,
  input  logic [NUM_HUBS*DATA_W-1:0]   tx_data,
  output logic [NUM_HUBS-1:0]          tx_ready,
  output logic [NUM_HUBS-1:0]          token_out,
  output logic                         bus_valid,
  output logic [IDX_W-1:0]             bus_dest,
  output logic [DATA_W-1:0]            bus_data,
  output logic                         bus_tail,
  output logic [NUM_HUBS-1:0]          rx_valid,
  output logic [NUM_HUBS*DATA_W-1:0]   rx_data,
  output logic [NUM_HUBS-1:0]          rx_tail,
  input  logic [NUM_HUBS-1:0]          rx_pop
);
  logic [IDX_W-1:0]    hold_idx;
  logic [NUM_HUBS-1:0] hold_oh;
  logic                grant, pass_evt;
  logic                sel_req, sel_head, sel_tail, sel_ok;
  logic [IDX_W-1:0]    sel_dest;
  logic [DATA_W-1:0]   sel_data;
  logic [NUM_HUBS-1:0] room;
  logic [IDX_W-1:0]    bus_src;

  // Holder's offer, selected by the token index.
  assign sel_req  = tx_valid[hold_idx];
  assign sel_head = tx_head[hold_idx];
  assign sel_tail = tx_tail[hold_idx];
  assign sel_dest = tx_dest[int'(hold_idx)*IDX_W +: IDX_W];
  assign sel_data = tx_data[int'(hold_idx)*DATA_W +: DATA_W];
  assign sel_ok   = (int'(sel_dest) < NUM_HUBS) && room[sel_dest];

  wtok_token_ring #(.NUM_HUBS(NUM_HUBS), .IDX_W(IDX_W)) ring_i (
    .clk(clk), .rst_n(rst_n), .req(sel_req), .req_head(sel_head),
    .req_tail(sel_tail), .dest_ok(sel_ok), .hold_idx(hold_idx),
    .hold_oh(hold_oh), .grant(grant), .pass_evt(pass_evt)
  );

  assign tx_ready  = hold_oh & {NUM_HUBS{grant}};
  assign token_out = hold_oh;

  // One-cycle broadcast medium.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_dest  <= '0;
      bus_data  <= '0;
      bus_tail  <= 1'b0;
      bus_src   <= '0;
    end else begin
      bus_valid <= grant;
      if (grant) begin
        bus_dest <= sel_dest;
        bus_data <= sel_data;
        bus_tail <= sel_tail;
        bus_src  <= hold_idx;
      end
    end
  end

  for (genvar k = 0; k < NUM_HUBS; k++) begin : g_hub
    wtok_rx_queue #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH), .IDX_W(IDX_W), .HUB_ID(k)) rxq_i (
      .clk(clk), .rst_n(rst_n), .bus_v(bus_valid), .bus_dest(bus_dest),
      .bus_data(bus_data), .bus_tail(bus_tail), .pop(rx_pop[k]),
      .q_valid(rx_valid[k]), .q_data(rx_data[k*DATA_W +: DATA_W]),
      .q_tail(rx_tail[k]), .has_room(room[k])
    );
  end

  // R2: at most one hub is granted per cycle
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_ready));
  // R3: the bus carries a flit only after a grant
  a_r3_bus_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $past(grant));
  // R5: a non-tail flit on the bus means its sender still holds the token
  a_r5_sender_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_tail) |-> hold_idx == bus_src);
endmodule

// File: tb/wtok_channel_tb_top.sv
`timescale 1ns/1ps
module wtok_channel_tb_top;
  localparam int K  = 4;
  localparam int W  = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [K-1:0]    tx_valid, tx_head, tx_tail, tx_ready, token_out;
  logic [K*IW-1:0] tx_dest;
  logic [K*W-1:0]  tx_data;
  logic            bus_valid, bus_tail;
  logic [IW-1:0]   bus_dest;
  logic [W-1:0]    bus_data;
  logic [K-1:0]    rx_valid, rx_tail, rx_pop;
  logic [K*W-1:0]  rx_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wtok_channel #(.NUM_HUBS(K), .DATA_W(W), .RX_DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_head(tx_head),
    .tx_tail(tx_tail), .tx_dest(tx_dest), .tx_data(tx_data),
    .tx_ready(tx_ready), .token_out(token_out), .bus_valid(bus_valid),
    .bus_dest(bus_dest), .bus_data(bus_data), .bus_tail(bus_tail),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_tail(rx_tail), .rx_pop(rx_pop)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(input int h, input bit v, input bit hd, input bit tl,
                       input int dst, input int dat);
    tx_valid[h] = v;
    tx_head[h]  = hd;
    tx_tail[h]  = tl;
    tx_dest[h*IW +: IW] = IW'(dst);
    tx_data[h*W +: W]   = W'(dat);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_valid = '0; tx_head = '0; tx_tail = '0;
    tx_dest = '0; tx_data = '0; rx_pop = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(token_out == 4'b0001, "R1 token", token_out, 1);
    chk(bus_valid == 1'b0 && rx_valid == '0, "R1 idle", {bus_valid, rx_valid}, 0);
  endtask

  // Two hubs request at once; one-flit packets to hubs 2 and 3.
  task automatic t_single();
    do_reset();
    drive(0, 1, 1, 1, 2, 16'hA0A0);
    drive(1, 1, 1, 1, 3, 16'hB1B1);
    rst_n = 1'b1;
    #1 chk(tx_ready == 4'b0001, "R2 only holder", tx_ready, 1);
    @(negedge clk); drive(0, 0, 0, 0, 0, 0); #1;
    chk(bus_valid && bus_data == 16'hA0A0 && bus_dest == 2 && bus_tail,
        "R3 bus flit", bus_data, 16'hA0A0);
    chk(token_out == 4'b0010, "R6 pass after tail", token_out, 2);
    chk(tx_ready == 4'b0010, "R2 next holder", tx_ready, 2);
    @(negedge clk); drive(1, 0, 0, 0, 0, 0); #1;
    chk(rx_valid == 4'b0100 && rx_data[2*W +: W] == 16'hA0A0,
        "R4 only dest stores", rx_valid, 4);
    @(negedge clk); #1;
    chk(rx_valid == 4'b1100 && rx_data[3*W +: W] == 16'hB1B1 && rx_tail[3],
        "R4 second dest", rx_valid, 12);
  endtask

  // Packet with a gap, then idle passing.
  task automatic t_gap_idle();
    do_reset();
    rst_n = 1'b1;
    while (token_out != 4'b0010) @(negedge clk);
    drive(1, 1, 1, 0, 0, 16'h0011);
    #1 chk(tx_ready[1] == 1'b1, "R5 head granted", tx_ready, 2);
    @(negedge clk); drive(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      #1 chk(token_out == 4'b0010, "R5 hold in gap", token_out, 2);
      @(negedge clk);
    end
    drive(1, 1, 0, 1, 0, 16'h0012);
    #1 chk(tx_ready[1] == 1'b1, "R5 tail granted", tx_ready, 2);
    @(negedge clk); drive(1, 0, 0, 0, 0, 0); #1;
    chk(token_out == 4'b0100, "R6 advance", token_out, 4);
    @(negedge clk); #1 chk(token_out == 4'b1000, "R7 idle pass", token_out, 8);
    @(negedge clk); #1 chk(token_out == 4'b0001, "R7 wrap", token_out, 1);
    chk($countones(token_out) == 1, "R9 one token", token_out, 1);
    chk(rx_valid[0] && rx_data[W-1:0] == 16'h0011, "R10 first", rx_data[W-1:0], 16'h0011);
  endtask

  // Ten-flit packet into an unpopped depth-8 queue.
  task automatic t_backpressure();
    int sent = 0;
    int blocked = 0;
    int guard = 0;
    int nxt = 16'h0200;
    do_reset();
    rst_n = 1'b1;
    @(negedge clk);
    while (sent < 10 && guard < 300) begin
      guard++;
      rx_pop = '0;
      drive(2, 1, sent == 0, sent == 9, 3, 16'h0200 + sent);
      #1;
      if (tx_ready[2]) sent++;
      else if (sent >= 8) begin
        blocked++;
        if (blocked == 3) begin
          chk(token_out == 4'b0100, "R8 holder keeps token", token_out, 4);
          chk(sent == 8, "R8 blocked at depth", sent, 8);
        end
        if (blocked % 3 == 0) begin
          chk(rx_data[3*W +: W] == W'(nxt), "R10 order", rx_data[3*W +: W], nxt);
          nxt++;
          rx_pop[3] = 1'b1;
        end
      end
      @(negedge clk);
    end
    rx_pop = '0;
    drive(2, 0, 0, 0, 0, 0);
    chk(sent == 10, "R8 resumes", sent, 10);
    @(negedge clk); @(negedge clk);
    while (rx_valid[3] && guard < 400) begin
      guard++;
      #1;
      chk(rx_data[3*W +: W] == W'(nxt), "R10 order", rx_data[3*W +: W], nxt);
      if (nxt == 16'h0209) chk(rx_tail[3], "R10 tail last", rx_tail[3], 1);
      nxt++;
      rx_pop[3] = 1'b1;
      @(negedge clk);
      rx_pop = '0;
    end
    chk(nxt == 16'h020A, "R10 all drained", nxt, 16'h020A);
    chk(rx_valid[2:0] == '0, "R4 others empty", rx_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_single();
    t_gap_idle();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule